// File: doc/BRIEF.md
# Lockstep Cipher Output Cross-Checker

This block sits between two identical block-cipher engines, both fed the same plaintext and key, and the memory path that receives the ciphertext. Each engine hands over one output byte per cycle together with an odd-parity bit. The block checks that parity and rebuilds it on each lane. It then compares the two rebuilt 9-bit words in the same cycle. The engines run in lockstep, so no buffering is needed. A byte that both lanes agree on goes downstream with fresh parity. Any disagreement raises a fault for the fault handler, which is expected to retry.

Key-parity errors reported by either engine are not fatal. They are recorded in their own status bits, which software reads when it chooses, and they never stop the data flow. A mismatch or an input-path parity error halts the block. While halted, no byte is passed on until software clears the bit that caused the halt. All four status bits are sticky and are cleared by writing ones.

Status bit positions: bit 0 is the lane mismatch fault, bit 1 is the key-parity error of engine A, bit 2 is the key-parity error of engine B, and bit 3 is the fatal input-path parity error.

Top module: `dual_cipher_checker`

## Requirements
- R1: After reset, `out_valid` is 0 and `stat` is 4'b0000.
- R2: When the block is not halted and both lanes are valid with good odd parity (the XOR of the 8 data bits and the parity bit is 1) and equal bytes, the next cycle shows `out_valid`=1, `out_data` equal to that byte, and `out_par` such that `out_data` and `out_par` together hold an odd number of ones.
- R3: When the block is not halted and both lanes are valid with good parity but different bytes, `stat[0]` is 1 in the next cycle and `out_valid` is 0.
- R4: When the block is not halted and exactly one lane is valid with good parity, `stat[0]` is 1 in the next cycle and `out_valid` is 0.
- R5: When the block is not halted and any valid lane has bad parity, `stat[3]` is 1 in the next cycle, `out_valid` is 0, and `stat[0]` is not set by that input.
- R6: A pulse on `a_key_perr` sets `stat[1]` and a pulse on `b_key_perr` sets `stat[2]` in the next cycle. Neither halts the block or blocks output.
- R7: While `stat[0]` or `stat[3]` is 1 (halted), lane inputs produce no output and do not set `stat[0]` or `stat[3]`.
- R8: Every `stat` bit stays set until a cycle with `clr_we`=1 and the matching `clr_mask` bit at 1. That cycle clears it, with effect from the next cycle. A set event in the same cycle takes priority over the clear, and bits whose mask bit is 0 are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_valid | input | 1 | Engine A byte present |
| a_byte | input | 8 | Engine A output byte |
| a_par | input | 1 | Engine A odd-parity bit |
| a_key_perr | input | 1 | Engine A key-parity error pulse |
| b_valid | input | 1 | Engine B byte present |
| b_byte | input | 8 | Engine B output byte |
| b_par | input | 1 | Engine B odd-parity bit |
| b_key_perr | input | 1 | Engine B key-parity error pulse |
| clr_we | input | 1 | Write-one-to-clear strobe for the status register |
| clr_mask | input | 4 | Status bits to clear |
| out_valid | output | 1 | Checked byte valid downstream |
| out_data | output | 8 | Checked byte |
| out_par | output | 1 | Regenerated odd-parity bit |
| stat | output | 4 | Sticky status: [0] mismatch, [1] key A, [2] key B, [3] path parity |

## Verification
Every result is due exactly one clock edge after its stimulus: the forwarded byte, each status bit being set, and each clear. The bench drives its inputs on the falling edge and runs one rising edge. It then samples on the next falling edge and compares against a bench model that is updated once per step. Random traffic mixes agreeing bytes with injected bit flips, one-sided bytes, parity corruption and key-error pulses. The status bits that halt the block are cleared on a later step, so that halted behaviour and the clear priority are both seen.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int ST_W    = 4;
  localparam int ST_MIS  = 0;
  localparam int ST_KEYA = 1;
  localparam int ST_KEYB = 2;
  localparam int ST_PATH = 3;

  typedef logic [ST_W-1:0] stat_t;
endpackage

// File: rtl/dcc_lane.sv
module dcc_lane #(
  parameter int DW = 8
) (
  input  logic          valid,
  input  logic [DW-1:0] data,
  input  logic          par,
  output logic [DW:0]   word,
  output logic          perr
);
  function automatic logic odd_fill(input logic [DW-1:0] d);
    return ~(^d);
  endfunction

  logic par_ok;
  assign par_ok = ((^data) ^ par);
  assign perr   = valid && !par_ok;
  assign word   = {odd_fill(data), data};
endmodule

// File: rtl/dcc_compare.sv
module dcc_compare #(
  parameter int DW = 8
) (
  input  logic        halted,
  input  logic        va,
  input  logic        vb,
  input  logic [DW:0] wa,
  input  logic [DW:0] wb,
  input  logic        perr_a,
  input  logic        perr_b,
  output logic        ev_path,
  output logic        ev_mis,
  output logic        ev_pass
);
  logic any_perr, one_sided, differ;
  assign any_perr  = perr_a || perr_b;
  assign one_sided = va ^ vb;
  assign differ    = va && vb && (wa != wb);

  always_comb begin
    ev_path = 1'b0;
    ev_mis  = 1'b0;
    ev_pass = 1'b0;
    if (!halted) begin
      if (any_perr)                 ev_path = 1'b1;
      else if (one_sided || differ) ev_mis  = 1'b1;
      else if (va)                  ev_pass = 1'b1;
    end
  end
endmodule

// File: rtl/dcc_status.sv
module dcc_status
  import dcc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  stat_t set_vec,
  input  logic  clr_we,
  input  stat_t clr_mask,
  output stat_t stat
);
  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               stat[i] <= 1'b0;
      else if (set_vec[i])      stat[i] <= 1'b1;
      else if (clr_we && clr_mask[i]) stat[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/dual_cipher_checker.sv
module dual_cipher_checker
  import dcc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_valid,
  input  logic [DW-1:0] a_byte,
  input  logic          a_par,
  input  logic          a_key_perr,
  input  logic          b_valid,
  input  logic [DW-1:0] b_byte,
  input  logic          b_par,
  input  logic          b_key_perr,
  input  logic          clr_we,
  input  logic [ST_W-1:0] clr_mask,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_par,
  output logic [ST_W-1:0] stat
);
  logic [DW:0] word_a, word_b;
  logic        perr_a, perr_b;
  logic        halted, ev_path, ev_mis, ev_pass;
  stat_t       set_vec;

  assign halted = stat[ST_MIS] || stat[ST_PATH];

  dcc_lane #(.DW(DW)) u_lane_a (
    .valid(a_valid), .data(a_byte), .par(a_par), .word(word_a), .perr(perr_a)
  );
  dcc_lane #(.DW(DW)) u_lane_b (
    .valid(b_valid), .data(b_byte), .par(b_par), .word(word_b), .perr(perr_b)
  );

  dcc_compare #(.DW(DW)) u_cmp (
    .halted(halted), .va(a_valid), .vb(b_valid), .wa(word_a), .wb(word_b),
    .perr_a(perr_a), .perr_b(perr_b),
    .ev_path(ev_path), .ev_mis(ev_mis), .ev_pass(ev_pass)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[ST_MIS]  = ev_mis;
    set_vec[ST_KEYA] = a_key_perr;
    set_vec[ST_KEYB] = b_key_perr;
    set_vec[ST_PATH] = ev_path;
  end

  dcc_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec),
    .clr_we(clr_we), .clr_mask(clr_mask), .stat(stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_par   <= 1'b1;
    end else begin
      out_valid <= ev_pass;
      if (ev_pass) begin
        out_data <= word_a[DW-1:0];
        out_par  <= word_a[DW];
      end
    end
  end
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_valid,
  input logic [DW-1:0] a_byte,
  input logic          a_par,
  input logic          a_key_perr,
  input logic          b_valid,
  input logic [DW-1:0] b_byte,
  input logic          b_par,
  input logic          b_key_perr,
  input logic          clr_we,
  input logic [3:0]    clr_mask,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic          out_par,
  input logic [3:0]    stat,
  input logic          halted
);
  logic a_ok, b_ok;
  assign a_ok = (^a_byte) ^ a_par;
  assign b_ok = (^b_byte) ^ b_par;

  AST_OUT_ODD_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((^out_data) ^ out_par)); // R2
  AST_MISMATCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && a_valid && b_valid && a_ok && b_ok && a_byte != b_byte)
      |=> (stat[0] && !out_valid)); // R3
  AST_ONE_SIDED_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && a_valid && !b_valid && a_ok) |=> (stat[0] && !out_valid)); // R4
  AST_PATH_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted && a_valid && !a_ok) |=> (stat[3] && !out_valid)); // R5
  AST_KEY_A_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    a_key_perr |=> stat[1]); // R6
  AST_KEY_B_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    b_key_perr |=> stat[2]); // R6
  AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> !out_valid); // R7
  AST_STICKY_MIS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[0] && !(clr_we && clr_mask[0])) |=> stat[0]); // R8
endmodule

bind dual_cipher_checker dcc_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .a_valid(a_valid), .a_byte(a_byte), .a_par(a_par), .a_key_perr(a_key_perr),
  .b_valid(b_valid), .b_byte(b_byte), .b_par(b_par), .b_key_perr(b_key_perr),
  .clr_we(clr_we), .clr_mask(clr_mask),
  .out_valid(out_valid), .out_data(out_data), .out_par(out_par),
  .stat(stat), .halted(halted)
);

// File: tb/dual_cipher_checker_bench.sv
module dual_cipher_checker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_valid = 0, b_valid = 0, a_par = 0, b_par = 0;
  logic [7:0] a_byte = 0, b_byte = 0;
  logic       a_key_perr = 0, b_key_perr = 0, clr_we = 0;
  logic [3:0] clr_mask = 0;
  logic       out_valid, out_par;
  logic [7:0] out_data;
  logic [3:0] stat;

  int checks = 0;
  int errors = 0;
  logic [3:0] m_stat = 0;
  logic       m_ov = 0;
  logic [7:0] m_data = 0;
  logic       done = 0;

  always #10 clk = ~clk;

  dual_cipher_checker u_dual_cipher_checker (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_byte(a_byte), .a_par(a_par), .a_key_perr(a_key_perr),
    .b_valid(b_valid), .b_byte(b_byte), .b_par(b_par), .b_key_perr(b_key_perr),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .out_valid(out_valid), .out_data(out_data), .out_par(out_par), .stat(stat)
  );

  function automatic logic good_par(input logic [7:0] d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    return (ones % 2 == 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict();
    logic halted, pa, pb;
    halted = m_stat[0] | m_stat[3];
    m_ov = 0;
    if (clr_we) m_stat = m_stat & ~clr_mask;
    if (!halted) begin
      pa = a_valid && (good_par(a_byte) != a_par);
      pb = b_valid && (good_par(b_byte) != b_par);
      if (pa || pb) m_stat[3] = 1;
      else if (a_valid != b_valid) m_stat[0] = 1;
      else if (a_valid && a_byte != b_byte) m_stat[0] = 1;
      else if (a_valid) begin m_ov = 1; m_data = a_byte; end
    end
    if (a_key_perr) m_stat[1] = 1;
    if (b_key_perr) m_stat[2] = 1;
  endtask

  task automatic step_check(input string req);
    predict();
    @(posedge clk);
    @(negedge clk);
    chk({req, " valid"}, out_valid, m_ov);
    chk({req, " stat"}, stat, m_stat);
    if (m_ov) begin
      chk({req, " data"}, out_data, m_data);
      chk({req, " parity"}, {31'b0, out_par}, {31'b0, good_par(m_data)});
    end
    a_valid = 0; b_valid = 0; a_key_perr = 0; b_key_perr = 0; clr_we = 0; clr_mask = 0;
  endtask

  task automatic drive(input logic va, input logic [7:0] da, input logic vb,
                       input logic [7:0] db);
    a_valid = va; a_byte = da; a_par = good_par(da);
    b_valid = vb; b_byte = db; b_par = good_par(db);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int seed;
    int r;
    logic [7:0] d;
    seed = 32'h5eed;
    void'($urandom(seed));
    @(negedge clk); @(negedge clk);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 stat", stat, 0);
    rst_n = 1;
    @(negedge clk);

    drive(1, 8'hA5, 1, 8'hA5); step_check("R2 match");
    drive(1, 8'h00, 1, 8'h00); step_check("R2 zero");
    drive(1, 8'h3C, 1, 8'h3D); step_check("R3 differ");
    drive(1, 8'h11, 1, 8'h11); step_check("R7 halted by mismatch");
    a_key_perr = 1; step_check("R6 key A while halted");
    clr_we = 1; clr_mask = 4'b0001; drive(1, 8'h44, 1, 8'h45); step_check("R8 clear vs halted input");
    drive(1, 8'h22, 1, 8'h22); b_key_perr = 1; step_check("R6 key B with pass");
    clr_we = 1; clr_mask = 4'b0010; a_key_perr = 1; step_check("R8 set wins");
    clr_we = 1; clr_mask = 4'b0100; step_check("R8 partial clear");
    drive(0, 8'h00, 1, 8'h77); step_check("R4 one sided B");
    clr_we = 1; clr_mask = 4'b0001; step_check("R8 clear mis");
    drive(1, 8'h77, 0, 8'h00); step_check("R4 one sided A");
    clr_we = 1; clr_mask = 4'b0001; step_check("R8 clear mis");
    drive(1, 8'h5A, 1, 8'h5A); b_par = ~b_par; step_check("R5 path parity");
    drive(1, 8'h5A, 1, 8'h5A); step_check("R7 halted by path");
    clr_we = 1; clr_mask = 4'b1111; step_check("R8 clear all");

    for (int n = 0; n < 600; n++) begin
      r = $urandom_range(0, 99);
      d = 8'($urandom);
      if (r < 65)      drive(1, d, 1, d);
      else if (r < 75) drive(0, 8'h00, 0, 8'h00);
      else if (r < 85) drive(1, d, 1, d ^ (8'h01 << $urandom_range(0, 7)));
      else if (r < 91) begin
        if (r[0]) drive(1, d, 0, 8'h00); else drive(0, 8'h00, 1, d);
      end else begin
        drive(1, d, 1, d);
        if (r[0]) a_par = ~a_par; else b_par = ~b_par;
      end
      if ($urandom_range(0, 19) == 0) a_key_perr = 1;
      if ($urandom_range(0, 19) == 0) b_key_perr = 1;
      if ((m_stat != 0) && $urandom_range(0, 2) == 0) begin
        clr_we = 1; clr_mask = 4'($urandom);
      end
      step_check("R2-random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule